// File: doc/BRIEF.md
# Systolic Multiply-Accumulate Cell with Step Counter

This block is one cell of a systolic matrix multiplier. Each cycle that carries a valid strobe, it multiplies two unsigned 8-bit operands and adds the product into a 32-bit running sum. Every finished multiply-accumulate step raises a one-cycle step pulse. A small counter tallies those pulses. Each dot product in the array has four real terms and three padding zeros, so the cell expects seven steps per result.

When the seventh step has been counted, the cell copies the running sum into its result register and pulses a result flag. In the same cycle it clears the accumulator and the counter, so the next dot product can begin at once.

On every step pulse, the cell also loads the operands of that step into a pair of forwarding registers. These registers feed the neighbouring cells to the right and below.

Top module: `pe_mac_cell`

## Requirements
- R1: A synchronous, active-high `rst` clears the following on the next clock edge: `stepDone`, `resultValid`, `result`, `fwdA` and `fwdB` all go to zero. The same edge also clears the step count and the running sum.
- R2: `stepDone` is high for exactly the one cycle after each clock edge that samples `inValid` high. It is low after every edge that samples `inValid` low.
- R3: The published `result` equals the sum of seven products `opA*opB`. Each product is unsigned, 16 bits wide and zero-extended to 32 bits.
- R4: `resultValid` is a one-cycle pulse. It rises on the second clock edge after the edge that raised the seventh `stepDone` pulse of a dot product. It never rises while fewer than seven steps have been counted.
- R5: `result` changes only on the edge where `resultValid` rises. It holds its value at all other times.
- R6: Idle cycles between steps do not advance the count. A dot product spread over any gaps publishes the same sum, timed from its seventh step.
- R7: The accumulator restarts from zero on the publish edge. A step whose valid is sampled on that same edge becomes the first term of the next dot product. The next valid may come at the earliest on the edge after the one that raised the seventh `stepDone`, plus one.
- R8: On each edge where `stepDone` is high, `fwdA` and `fwdB` load the operands sampled together with the `inValid` that produced that pulse. On all other edges they hold their values.
- R9: A reset in the middle of a dot product discards the partial sum and the partial count. The next seven steps form a fresh result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands on `opA`/`opB` form one step this cycle |
| opA | input | 8 | Row operand, unsigned |
| opB | input | 8 | Column operand, unsigned |
| fwdA | output | 8 | Row operand forwarded to the next cell |
| fwdB | output | 8 | Column operand forwarded to the next cell |
| stepDone | output | 1 | One-cycle pulse per completed step |
| resultValid | output | 1 | One-cycle pulse when a new result is published |
| result | output | 32 | Last published dot product |

## Verification
The bound checker watches local timing on every cycle:
- a step pulse follows every valid and only a valid;
- the forwarding registers and `result` hold between their load strobes;
- `resultValid` is a single pulse that trails a step pulse by two cycles;
- reset clears every output.

What the checker cannot see is whether the count reaches exactly seven. That needs the bench's scenarios: dot products with different gap patterns, an incomplete set of six steps, a restart on the publish edge, and a reset in the middle of a dot product. Each scenario compares the published sum with one computed arithmetically from the operands that were applied.

// File: rtl/pe_pkg.sv
package pe_pkg;

  // Strobes from the step counter to the datapath.
  typedef struct packed {
    logic publish;   // count complete: latch result, restart accumulator
    logic countHit;  // mirrors publish for the datapath's result register enable
  } pe_strobe_t;

endpackage

// File: rtl/pe_datapath.sv
module pe_datapath
  import pe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  pe_strobe_t        strb,
  output logic              stepDone,
  output logic [DATA_W-1:0] fwdA,
  output logic [DATA_W-1:0] fwdB,
  output logic [ACC_W-1:0]  result
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int PAD_W  = ACC_W - PROD_W;

  logic [PROD_W-1:0] product;
  logic [ACC_W-1:0]  productExt;
  logic [ACC_W-1:0]  accBase;
  logic [ACC_W-1:0]  acc;
  logic [DATA_W-1:0] stageA;
  logic [DATA_W-1:0] stageB;

  assign product    = opA * opB;
  assign productExt = {{PAD_W{1'b0}}, product};
  assign accBase    = strb.publish ? '0 : acc;

  // Multiply-accumulate stage with step pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      stepDone <= 1'b0;
      stageA   <= '0;
      stageB   <= '0;
    end else begin
      stepDone <= inValid;
      if (inValid) begin
        acc    <= accBase + productExt;
        stageA <= opA;
        stageB <= opB;
      end else begin
        acc <= accBase;
      end
    end
  end

  // Operand forwarding, loaded only on completed steps.
  always_ff @(posedge clk) begin
    if (rst) begin
      fwdA <= '0;
      fwdB <= '0;
    end else if (stepDone) begin
      fwdA <= stageA;
      fwdB <= stageB;
    end
  end

  // Result register.
  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (strb.countHit) begin
      result <= acc;
    end
  end

endmodule

// File: rtl/pe_control.sv
module pe_control
  import pe_pkg::*;
#(
  parameter int STEP_COUNT = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stepDone,
  output pe_strobe_t strb,
  output logic       resultValid
);

  localparam int CNT_W = $clog2(STEP_COUNT + 1);

  logic [CNT_W-1:0] stepCnt;
  logic [CNT_W-1:0] stepCntNext;
  logic             full;

  assign full        = (stepCnt == CNT_W'(STEP_COUNT));
  assign stepCntNext = (rst || full) ? '0 : stepCnt + CNT_W'(stepDone);

  always_ff @(posedge clk) begin
    stepCnt <= stepCntNext;
    if (rst) begin
      resultValid <= 1'b0;
    end else begin
      resultValid <= full;
    end
  end

  assign strb.publish  = full;
  assign strb.countHit = full;

endmodule

// File: rtl/pe_mac_cell.sv
module pe_mac_cell
  import pe_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ACC_W      = 32,
  parameter int STEP_COUNT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] fwdA,
  output logic [DATA_W-1:0] fwdB,
  output logic              stepDone,
  output logic              resultValid,
  output logic [ACC_W-1:0]  result
);

  pe_strobe_t strb;

  pe_control #(.STEP_COUNT(STEP_COUNT)) uCtrl (
    .clk         (clk),
    .rst         (rst),
    .stepDone    (stepDone),
    .strb        (strb),
    .resultValid (resultValid)
  );

  pe_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W)) uDp (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opA      (opA),
    .opB      (opB),
    .strb     (strb),
    .stepDone (stepDone),
    .fwdA     (fwdA),
    .fwdB     (fwdB),
    .result   (result)
  );

endmodule

// File: rtl/pe_mac_cell_chk.sv
module pe_mac_cell_chk #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              stepDone,
  input logic              resultValid,
  input logic [ACC_W-1:0]  result,
  input logic [DATA_W-1:0] fwdA,
  input logic [DATA_W-1:0] fwdB
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!stepDone && !resultValid && result == '0 && fwdA == '0 && fwdB == '0));

  // R2
  done_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> stepDone);

  // R2
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !stepDone);

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> !resultValid);

  // R4
  publish_after_step_chk: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> $past(stepDone, 2));

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (resultValid || $stable(result)));

  // R8
  fwd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stepDone |=> ($stable(fwdA) && $stable(fwdB)));

endmodule

bind pe_mac_cell pe_mac_cell_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) uChk (
  .clk         (clk),
  .rst         (rst),
  .inValid     (inValid),
  .stepDone    (stepDone),
  .resultValid (resultValid),
  .result      (result),
  .fwdA        (fwdA),
  .fwdB        (fwdB)
);

// File: tb/sim_pe_mac_cell.sv
`timescale 1ns/1ps
module sim_pe_mac_cell;

  localparam int STEPS = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [7:0]  opA = '0;
  logic [7:0]  opB = '0;
  logic [7:0]  fwdA, fwdB;
  logic        stepDone, resultValid;
  logic [31:0] result;

  int vectors = 0;
  int fails   = 0;

  // bench-side expectation state
  logic        v1 = 0, v2 = 0;
  logic [7:0]  a1 = 0, b1 = 0, a2 = 0, b2 = 0;
  logic [7:0]  eFwdA = 0, eFwdB = 0;
  logic        eRv = 0;
  logic [31:0] eResult = 0, runSum = 0, dotSum = 0;
  int          steps = 0;
  int          rvWait = 0;
  string       curTag = "R3";

  always #2 clk = ~clk;

  pe_mac_cell u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .fwdA(fwdA), .fwdB(fwdB), .stepDone(stepDone),
    .resultValid(resultValid), .result(result)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clearModel();
    v1 = 0; v2 = 0; a1 = 0; b1 = 0; a2 = 0; b2 = 0;
    eFwdA = 0; eFwdB = 0; eRv = 0; eResult = 0;
    runSum = 0; dotSum = 0; steps = 0; rvWait = 0;
  endtask

  // one clock: drive at negedge, model the edge, check at next negedge
  task automatic cycle(input logic v, input logic [7:0] a, input logic [7:0] b);
    inValid = v; opA = a; opB = b;
    @(posedge clk);
    v2 = v1; a2 = a1; b2 = b1;
    v1 = v;  a1 = a;  b1 = b;
    if (v2) begin eFwdA = a2; eFwdB = b2; end
    eRv = 0;
    if (rvWait > 0) begin
      rvWait--;
      if (rvWait == 0) begin eRv = 1; eResult = dotSum; end
    end
    if (v) begin
      runSum += {24'b0, a} * {24'b0, b};
      steps++;
      if (steps == STEPS) begin
        dotSum = runSum; runSum = 0; steps = 0; rvWait = 2;
      end
    end
    @(negedge clk);
    chk("R2 stepDone", {31'b0, stepDone}, {31'b0, v1});
    chk("R4 resultValid", {31'b0, resultValid}, {31'b0, eRv});
    chk(eRv ? {curTag, " result"} : "R5 result hold", result, eResult);
    chk("R8 fwdA", {24'b0, fwdA}, {24'b0, eFwdA});
    chk("R8 fwdB", {24'b0, fwdB}, {24'b0, eFwdB});
  endtask

  task automatic doReset(input string tag);
    rst = 1'b1; inValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    clearModel();
    chk({tag, " stepDone"}, {31'b0, stepDone}, 32'd0);
    chk({tag, " resultValid"}, {31'b0, resultValid}, 32'd0);
    chk({tag, " result"}, result, 32'd0);
    chk({tag, " fwdA"}, {24'b0, fwdA}, 32'd0);
    chk({tag, " fwdB"}, {24'b0, fwdB}, 32'd0);
  endtask

  task automatic runDot(input int gap, input int seed, input int postIdle);
    for (int i = 0; i < STEPS; i++) begin
      cycle(1'b1, 8'((seed * 53 + i * 29 + 7) & 255), 8'((seed * 91 + i * 13 + 200) & 255));
      if (i < STEPS - 1)
        for (int g = 0; g < gap; g++) cycle(1'b0, 8'hA5, 8'h5A);
    end
    for (int g = 0; g < postIdle; g++) cycle(1'b0, 8'h00, 8'h00);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    doReset("R1");

    // R3: back-to-back steps, and the all-ones extreme
    curTag = "R3";
    runDot(0, 1, 3);
    for (int i = 0; i < STEPS; i++) cycle(1'b1, 8'hFF, 8'hFF);
    repeat (3) cycle(1'b0, 8'h00, 8'h00);

    // R6: gaps of varying length between steps
    curTag = "R6";
    for (int g = 1; g <= 4; g++) runDot(g, g + 10, 3);
    for (int i = 0; i < STEPS; i++) begin
      cycle(1'b1, 8'(i * 37 + 3), 8'(250 - i * 11));
      repeat ((i * 3) % 5) cycle(1'b0, 8'h11, 8'h22);
    end
    repeat (3) cycle(1'b0, 8'h00, 8'h00);

    // R4: six steps never publish; the seventh after a long pause does
    curTag = "R4";
    for (int i = 0; i < STEPS - 1; i++) cycle(1'b1, 8'(i + 1), 8'(i + 2));
    repeat (12) cycle(1'b0, 8'hFF, 8'hFF);
    cycle(1'b1, 8'd9, 8'd9);
    repeat (3) cycle(1'b0, 8'h00, 8'h00);

    // R7: next dot product begins on the publish edge
    curTag = "R7";
    runDot(0, 21, 1);
    runDot(0, 22, 1);
    runDot(2, 23, 1);
    repeat (3) cycle(1'b0, 8'h00, 8'h00);

    // R9: reset in the middle of a dot product
    for (int i = 0; i < 4; i++) cycle(1'b1, 8'hEE, 8'hDD);
    doReset("R9");
    curTag = "R9";
    runDot(1, 31, 3);

    // sweep over many dot products with mixed gaps
    curTag = "R3";
    for (int d = 0; d < 40; d++) runDot(d % 4, d + 100, 1 + (d % 3));
    repeat (4) cycle(1'b0, 8'h00, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule